// File: doc/BRIEF.md
# Positional Packet Router for a Daisy-Chained Node

This block lives in one node of a daisy chain of identical nodes. The node has no address; it finds its role from where packets fall in the stream. Commands arrive as 4-byte packets on an upstream input stream. The first packet after a link reset belongs to this node. It is kept, checked and handed to the local command interface. Every later packet in the transaction is passed out on the downstream output stream as it is, without being inspected, and the node counts the whole packets it passed on. That count is the number of nodes beyond this one.

Once the transaction's last byte has been taken, the node builds its own 4-byte response: a status byte, two data bytes and a checksum. The node holds its response back until the first downstream response byte shows up, or until a cycle-count timeout runs out. It then sends its own response upstream, followed by every downstream response byte in the order they arrive. If it forwarded nothing, it is the end of the chain and answers at once. A timeout raises a sticky flag that marks the downstream side as missing.

All four byte streams use valid/ready. A sender keeps valid and data steady until ready is seen at a clock edge. Ready may depend on valid, and a byte moves on each edge where both are high. `link_reset` is a one-cycle synchronous restart of the protocol. `rst_n` is the asynchronous reset of the whole block.

Top module: `chain_pop_router`

## Requirements
- R1: The first packet taken after a reset or link reset is never forwarded. When its checksum is good and its command byte is not 0x00, `cmd_valid` pulses high for exactly one cycle with `cmd_op` set to byte 0 and `cmd_arg` set to {byte 1, byte 2}.
- R2: Every later packet comes out on the downstream output byte for byte and unchanged. `ds_out_last` follows `us_in_last`.
- R3: `ds_count` holds the number of complete 4-byte packets forwarded since the last reset or link reset.
- R4: A packet is good when its four bytes sum to 0 modulo 256. The own response is {status, data high, data low, check}, where check makes the four bytes sum to 0. Status is 0x06 for a good packet and 0x15 for a bad one. A bad packet gets zero data and no `cmd_valid`.
- R5: A good command with bit 7 set is a query. Its response data is `query_data`, sampled when the command's last byte is taken. Every other command returns zero data. Command 0x00 (ping) produces only its acknowledge.
- R6: The upstream response is the node's own 4 bytes first. The relayed downstream bytes follow in the order they arrive, 4 for each forwarded packet. `us_out_last` is high only on the final byte.
- R7: When `ds_count` is non-zero, `us_out_valid` stays low until a downstream response byte has been offered. When `ds_count` is zero, the own response starts within 4 cycles of the last upstream byte being taken.
- R8: If no downstream byte is offered for TIMEOUT cycles, the node sends only its own response and sets `ds_missing`. The flag stays set through link resets and clears only on `rst_n`.
- R9: `link_reset` clears the forward count, the response progress and the consumed command, so the next packet is again taken as this node's own.
- R10: Valid and data hold while ready is low. `us_in_ready` is low from the transaction's last byte until a link reset. `ds_in_ready` is low except while the node is relaying.
- R11: After `rst_n`, all valid outputs, `cmd_valid`, `ds_count` and `ds_missing` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_reset | input | 1 | Synchronous protocol restart pulse |
| us_in_valid | input | 1 | Upstream command byte valid |
| us_in_ready | output | 1 | Upstream command byte ready |
| us_in_data | input | 8 | Upstream command byte |
| us_in_last | input | 1 | Marks the final byte of the transaction |
| ds_out_valid | output | 1 | Forwarded byte valid |
| ds_out_ready | input | 1 | Forwarded byte ready |
| ds_out_data | output | 8 | Forwarded byte |
| ds_out_last | output | 1 | Final forwarded byte of the transaction |
| ds_in_valid | input | 1 | Downstream response byte valid |
| ds_in_ready | output | 1 | Downstream response byte ready |
| ds_in_data | input | 8 | Downstream response byte |
| us_out_valid | output | 1 | Upstream response byte valid |
| us_out_ready | input | 1 | Upstream response byte ready |
| us_out_data | output | 8 | Upstream response byte |
| us_out_last | output | 1 | Final byte of the response stream |
| cmd_valid | output | 1 | One-cycle pulse: local command issued |
| cmd_op | output | 8 | Local command byte |
| cmd_arg | output | 16 | Local command argument |
| query_data | input | 16 | Local value returned by query commands |
| ds_count | output | CNT_W | Packets forwarded (nodes beyond this one) |
| ds_missing | output | 1 | Sticky downstream-timeout flag |

## Verification
The hardest case to reach from the ports is the race between the downstream answer and the timeout. The node must hold its own response while downstream bytes are already waiting, and then relay them after it. It must also give up cleanly when nothing comes back. The stimulus drives a downstream responder that answers only after the forwarded stream's last byte, with a random delay kept under the timeout. A directed run withholds the answer entirely and measures the silent interval. After that, a link reset is followed by a normal transaction to show the missing flag survives until `rst_n`. Random ready throttling on both outputs keeps the node stalled in the middle of its own response and in the middle of relaying.

// File: rtl/cnr_pkg.sv
package cnr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] ACK_CODE = 8'h06;
  localparam logic [7:0] NAK_CODE = 8'h15;
  localparam logic [7:0] PING_OP  = 8'h00;

  typedef enum logic [2:0] {EG_IDLE, EG_WAIT, EG_OWN, EG_RELAY, EG_DONE} eg_state_t;

  typedef struct packed {
    logic [7:0]  status;
    logic [15:0] data;
  } own_rsp_t;

  // byte that makes the three given bytes plus itself sum to zero
  function automatic logic [7:0] neg_sum3(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] c);
    logic [7:0] s;
    s = a + b + c;
    return ~s + 8'd1;
  endfunction
endpackage

// File: rtl/cnr_ingress.sv
module cnr_ingress
  import cnr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_reset,
  input  logic             us_in_valid,
  output logic             us_in_ready,
  input  logic [7:0]       us_in_data,
  input  logic             us_in_last,
  output logic             ds_out_valid,
  input  logic             ds_out_ready,
  output logic [7:0]       ds_out_data,
  output logic             ds_out_last,
  input  logic [15:0]      query_data,
  output logic             cmd_valid,
  output logic [7:0]       cmd_op,
  output logic [15:0]      cmd_arg,
  output own_rsp_t         own_rsp,
  output logic             txn_done,
  output logic [CNT_W-1:0] ds_count
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [1:0] byte_idx;
  logic       consumed;
  logic [7:0] b0, b1, b2;
  logic [7:0] sum4;
  logic       pkt_ok, in_fire;

  assign us_in_ready  = !txn_done && (consumed ? ds_out_ready : 1'b1);
  assign ds_out_valid = consumed && !txn_done && us_in_valid;
  assign ds_out_data  = us_in_data;
  assign ds_out_last  = us_in_last;
  assign in_fire      = us_in_valid && us_in_ready;
  assign sum4         = b0 + b1 + b2 + us_in_data;
  assign pkt_ok       = (sum4 == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx <= '0; consumed <= 1'b0; txn_done <= 1'b0;
      b0 <= '0; b1 <= '0; b2 <= '0;
      cmd_valid <= 1'b0; cmd_op <= '0; cmd_arg <= '0;
      own_rsp <= '0; ds_count <= '0;
    end else if (link_reset) begin
      byte_idx <= '0; consumed <= 1'b0; txn_done <= 1'b0;
      b0 <= '0; b1 <= '0; b2 <= '0;
      cmd_valid <= 1'b0; cmd_op <= '0; cmd_arg <= '0;
      own_rsp <= '0; ds_count <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (in_fire) begin
        byte_idx <= byte_idx + 2'd1;
        if (us_in_last) txn_done <= 1'b1;
        if (!consumed) begin
          case (byte_idx)
            2'd0: b0 <= us_in_data;
            2'd1: b1 <= us_in_data;
            2'd2: b2 <= us_in_data;
            default: begin
              consumed       <= 1'b1;
              own_rsp.status <= pkt_ok ? ACK_CODE : NAK_CODE;
              own_rsp.data   <= (pkt_ok && b0[7]) ? query_data : 16'h0000;
              if (pkt_ok && (b0 != PING_OP)) begin
                cmd_valid <= 1'b1;
                cmd_op    <= b0;
                cmd_arg   <= {b1, b2};
              end
            end
          endcase
        end else if (byte_idx == 2'd3 && ds_count != '1) begin
          ds_count <= ds_count + CNT_ONE;
        end
      end
    end
  end

  // R1
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R3
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_reset |=> (ds_count >= $past(ds_count)));

  // R10
  ds_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_out_valid && !ds_out_ready && !link_reset) |=> (ds_out_valid && $stable(ds_out_data)));
endmodule

// File: rtl/cnr_egress.sv
module cnr_egress
  import cnr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_reset,
  input  logic             txn_done,
  input  logic [CNT_W-1:0] ds_count,
  input  own_rsp_t         own_rsp,
  input  logic             ds_in_valid,
  output logic             ds_in_ready,
  input  logic [7:0]       ds_in_data,
  output logic             us_out_valid,
  input  logic             us_out_ready,
  output logic [7:0]       us_out_data,
  output logic             us_out_last,
  output logic             ds_missing
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam int RLY_W = CNT_W + 2;
  localparam logic [TMR_W-1:0] TMR_ONE  = 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);
  localparam logic [RLY_W-1:0] RLY_ONE  = 1;

  eg_state_t        st;
  logic [TMR_W-1:0] tmr;
  logic [1:0]       oidx;
  logic             relay_en;
  logic [RLY_W-1:0] rcnt;
  logic [RLY_W-1:0] rly_last;
  logic [7:0]       own_byte;

  assign rly_last = {ds_count, 2'b00} - RLY_ONE;

  always_comb begin
    case (oidx)
      2'd0:    own_byte = own_rsp.status;
      2'd1:    own_byte = own_rsp.data[15:8];
      2'd2:    own_byte = own_rsp.data[7:0];
      default: own_byte = neg_sum3(own_rsp.status, own_rsp.data[15:8], own_rsp.data[7:0]);
    endcase
  end

  always_comb begin
    us_out_valid = 1'b0;
    us_out_data  = own_byte;
    us_out_last  = 1'b0;
    ds_in_ready  = 1'b0;
    case (st)
      EG_OWN: begin
        us_out_valid = 1'b1;
        us_out_last  = (oidx == 2'd3) && !relay_en;
      end
      EG_RELAY: begin
        us_out_valid = ds_in_valid;
        us_out_data  = ds_in_data;
        us_out_last  = (rcnt == rly_last);
        ds_in_ready  = us_out_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= EG_IDLE; tmr <= '0; oidx <= '0; relay_en <= 1'b0; rcnt <= '0;
      ds_missing <= 1'b0;
    end else if (link_reset) begin
      st <= EG_IDLE; tmr <= '0; oidx <= '0; relay_en <= 1'b0; rcnt <= '0;
    end else begin
      case (st)
        EG_IDLE: if (txn_done) begin
          if (ds_count == '0) begin
            st <= EG_OWN; relay_en <= 1'b0;
          end else begin
            st <= EG_WAIT; tmr <= '0;
          end
        end
        EG_WAIT: begin
          if (ds_in_valid) begin
            st <= EG_OWN; relay_en <= 1'b1;
          end else if (tmr == TMR_LAST) begin
            st <= EG_OWN; relay_en <= 1'b0; ds_missing <= 1'b1;
          end else begin
            tmr <= tmr + TMR_ONE;
          end
        end
        EG_OWN: if (us_out_ready) begin
          oidx <= oidx + 2'd1;
          if (oidx == 2'd3) st <= relay_en ? EG_RELAY : EG_DONE;
        end
        EG_RELAY: if (ds_in_valid && us_out_ready) begin
          rcnt <= rcnt + RLY_ONE;
          if (rcnt == rly_last) st <= EG_DONE;
        end
        default: ;
      endcase
    end
  end

  // R8
  missing_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_missing |=> ds_missing);

  // R10
  us_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (us_out_valid && !us_out_ready && !link_reset) |=> (us_out_valid && $stable(us_out_data)));

  // R7
  own_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == EG_WAIT) && ds_in_valid && !link_reset) |=>
      (us_out_valid && (us_out_data == own_rsp.status)));
endmodule

// File: rtl/chain_pop_router.sv
module chain_pop_router
  import cnr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_reset,
  input  logic             us_in_valid,
  output logic             us_in_ready,
  input  logic [7:0]       us_in_data,
  input  logic             us_in_last,
  output logic             ds_out_valid,
  input  logic             ds_out_ready,
  output logic [7:0]       ds_out_data,
  output logic             ds_out_last,
  input  logic             ds_in_valid,
  output logic             ds_in_ready,
  input  logic [7:0]       ds_in_data,
  output logic             us_out_valid,
  input  logic             us_out_ready,
  output logic [7:0]       us_out_data,
  output logic             us_out_last,
  output logic             cmd_valid,
  output logic [7:0]       cmd_op,
  output logic [15:0]      cmd_arg,
  input  logic [15:0]      query_data,
  output logic [CNT_W-1:0] ds_count,
  output logic             ds_missing
);
  own_rsp_t own_rsp;
  logic     txn_done;

  cnr_ingress #(.CNT_W(CNT_W)) u_ingress (
    .clk(clk), .rst_n(rst_n), .link_reset(link_reset),
    .us_in_valid(us_in_valid), .us_in_ready(us_in_ready),
    .us_in_data(us_in_data), .us_in_last(us_in_last),
    .ds_out_valid(ds_out_valid), .ds_out_ready(ds_out_ready),
    .ds_out_data(ds_out_data), .ds_out_last(ds_out_last),
    .query_data(query_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .own_rsp(own_rsp), .txn_done(txn_done), .ds_count(ds_count)
  );

  cnr_egress #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_egress (
    .clk(clk), .rst_n(rst_n), .link_reset(link_reset),
    .txn_done(txn_done), .ds_count(ds_count), .own_rsp(own_rsp),
    .ds_in_valid(ds_in_valid), .ds_in_ready(ds_in_ready), .ds_in_data(ds_in_data),
    .us_out_valid(us_out_valid), .us_out_ready(us_out_ready),
    .us_out_data(us_out_data), .us_out_last(us_out_last), .ds_missing(ds_missing)
  );
endmodule

// File: tb/test_chain_pop_router.sv
`timescale 1ns/1ps
module test_chain_pop_router;
  localparam int TO = 60;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, link_reset;
  logic us_in_valid, us_in_ready, us_in_last;
  logic [7:0] us_in_data;
  logic ds_out_valid, ds_out_ready, ds_out_last;
  logic [7:0] ds_out_data;
  logic ds_in_valid, ds_in_ready;
  logic [7:0] ds_in_data;
  logic us_out_valid, us_out_ready, us_out_last;
  logic [7:0] us_out_data;
  logic cmd_valid;
  logic [7:0] cmd_op;
  logic [15:0] cmd_arg, query_data;
  logic [7:0] ds_count;
  logic ds_missing;

  chain_pop_router #(.CNT_W(8), .TIMEOUT(TO)) i_chain_pop_router (.*);

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] tx [64];   int ntx;
  logic [7:0] dsr [64];
  logic [7:0] dso [64];  logic dsl [64]; int ndso;
  logic [7:0] uso [64];  logic usl [64]; int nuso;
  logic [7:0] got_op; logic [15:0] got_arg; int ncmd;
  bit ds_last_seen, up_done, exp_missing;
  int in_last_cyc, first_vld_cyc, first_dsin_cyc;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fix_chk(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    logic [7:0] s;
    s = a + b + c;
    return 8'h00 - s;
  endfunction

  always @(negedge clk) begin
    if (ds_out_valid && ds_out_ready) begin
      dso[ndso] = ds_out_data; dsl[ndso] = ds_out_last; ndso++;
      if (ds_out_last) ds_last_seen = 1'b1;
    end
    if (us_out_valid && first_vld_cyc < 0) first_vld_cyc = cyc;
    if (us_out_valid && us_out_ready) begin
      uso[nuso] = us_out_data; usl[nuso] = us_out_last; nuso++;
      if (us_out_last) up_done = 1'b1;
    end
    if (us_in_valid && us_in_ready && us_in_last) in_last_cyc = cyc;
    if (ds_in_valid && first_dsin_cyc < 0) first_dsin_cyc = cyc;
    if (cmd_valid) begin ncmd++; got_op = cmd_op; got_arg = cmd_arg; end
  end

  initial begin
    ds_out_ready = 1'b1; us_out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      ds_out_ready = ($urandom % 4) != 0;
      us_out_ready = ($urandom % 4) != 0;
    end
  end

  task automatic send_up(input int n);
    for (int i = 0; i < n; i++) begin
      bit fired;
      if ($urandom % 5 == 0) begin
        us_in_valid = 1'b0;
        @(posedge clk); #1;
      end
      us_in_valid = 1'b1; us_in_data = tx[i]; us_in_last = (i == n - 1);
      forever begin
        @(negedge clk); fired = us_in_ready;
        @(posedge clk); #1;
        if (fired) break;
      end
    end
    us_in_valid = 1'b0; us_in_last = 1'b0;
  endtask

  task automatic send_ds(input int n);
    for (int i = 0; i < n; i++) begin
      bit fired;
      ds_in_valid = 1'b1; ds_in_data = dsr[i];
      forever begin
        @(negedge clk); fired = ds_in_ready;
        @(posedge clk); #1;
        if (fired) break;
      end
    end
    ds_in_valid = 1'b0;
  endtask

  // mode 0: downstream answers after dly cycles; mode 1: downstream silent
  task automatic run_txn(input int npk, input bit bad, input logic [7:0] op,
                         input logic [15:0] arg, input int mode, input int dly);
    logic [7:0] exp [64]; int nexp; bit good; logic [15:0] qd;
    @(posedge clk); #1; link_reset = 1'b1;
    @(posedge clk); #1; link_reset = 1'b0;
    ndso = 0; nuso = 0; ncmd = 0; ds_last_seen = 0; up_done = 0;
    in_last_cyc = -1; first_vld_cyc = -1; first_dsin_cyc = -1;
    // R9: link reset clears the forward count
    chk(ds_count == 8'd0, "R9", "count after link reset", ds_count, 0);
    qd = 16'($urandom); query_data = qd;
    tx[0] = op; tx[1] = arg[15:8]; tx[2] = arg[7:0];
    tx[3] = fix_chk(op, arg[15:8], arg[7:0]) ^ (bad ? 8'h5A : 8'h00);
    ntx = 4 * (1 + npk);
    for (int i = 4; i < ntx; i++) tx[i] = 8'($urandom);
    for (int i = 0; i < 4 * npk; i++) dsr[i] = 8'($urandom);
    fork
      send_up(ntx);
      begin
        if (npk > 0 && mode == 0) begin
          wait (ds_last_seen);
          repeat (dly) @(posedge clk);
          #1; send_ds(4 * npk);
        end
      end
    join
    wait (up_done);
    repeat (3) @(posedge clk);
    @(negedge clk);
    good = !bad;
    // R1, R2: first packet kept, the rest forwarded unchanged
    chk(ndso == 4 * npk, "R1", "forwarded byte count", ndso, 4 * npk);
    for (int i = 0; i < ndso && i < 4 * npk; i++) begin
      chk(dso[i] == tx[i + 4], "R2", "forwarded byte", dso[i], tx[i + 4]);
      chk(dsl[i] == (i == 4 * npk - 1), "R2", "forwarded last flag", dsl[i], i == 4 * npk - 1);
    end
    // R3
    chk(ds_count == 8'(npk), "R3", "forward count", ds_count, npk);
    // R1, R5: local command issue
    if (good && op != 8'h00) begin
      chk(ncmd == 1, "R1", "cmd pulses", ncmd, 1);
      chk(got_op == op && got_arg == arg, "R1", "cmd fields", {got_op, got_arg}, {op, arg});
    end else begin
      chk(ncmd == 0, (good ? "R5" : "R4"), "cmd pulses for ping or bad", ncmd, 0);
    end
    // R4, R5, R6: response content and order
    exp[0] = good ? 8'h06 : 8'h15;
    {exp[1], exp[2]} = (good && op[7]) ? qd : 16'h0000;
    exp[3] = fix_chk(exp[0], exp[1], exp[2]);
    nexp = 4;
    if (mode == 0) for (int i = 0; i < 4 * npk; i++) begin exp[nexp] = dsr[i]; nexp++; end
    chk(nuso == nexp, "R6", "response byte count", nuso, nexp);
    for (int i = 0; i < nuso && i < nexp; i++) begin
      chk(uso[i] == exp[i], (i < 4 ? "R4" : "R6"), "response byte", uso[i], exp[i]);
      chk(usl[i] == (i == nexp - 1), "R6", "response last flag", usl[i], i == nexp - 1);
    end
    // R7, R8: response timing
    if (npk == 0)
      chk(first_vld_cyc - in_last_cyc <= 4, "R7", "end-of-chain latency", first_vld_cyc - in_last_cyc, 4);
    else if (mode == 0)
      chk(first_vld_cyc > first_dsin_cyc, "R7", "own response before downstream", first_vld_cyc, first_dsin_cyc + 1);
    else
      chk(first_vld_cyc - in_last_cyc >= TO, "R8", "timeout wait", first_vld_cyc - in_last_cyc, TO);
    if (mode == 1 && npk > 0) exp_missing = 1'b1;
    chk(ds_missing == exp_missing, "R8", "missing flag", ds_missing, exp_missing);
    // R10: no more upstream bytes accepted after the last one
    chk(us_in_ready == 1'b0, "R10", "upstream ready after last", us_in_ready, 0);
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk); #1; rst_n = 1'b1;
    exp_missing = 1'b0;
    @(negedge clk);
    // R11
    chk(ds_missing == 0 && ds_count == 0, "R11", "flag and count after reset", {ds_missing, ds_count}, 0);
    chk(!us_out_valid && !ds_out_valid && !cmd_valid, "R11", "valids after reset",
        {us_out_valid, ds_out_valid, cmd_valid}, 0);
    chk(!ds_in_ready, "R10", "downstream ready while idle", ds_in_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; link_reset = 1'b0; exp_missing = 1'b0;
    us_in_valid = 1'b0; us_in_data = '0; us_in_last = 1'b0;
    ds_in_valid = 1'b0; ds_in_data = '0; query_data = '0;
    do_reset();
    run_txn(0, 0, 8'h00, 16'h0000, 0, 0);      // ping, end of chain
    run_txn(0, 0, 8'h83, 16'hBEEF, 0, 0);      // query, end of chain
    run_txn(2, 1, 8'h11, 16'h1234, 0, 5);      // bad checksum, relay
    run_txn(3, 0, 8'h00, 16'h0000, 0, 0);      // ping filler, immediate answer
    run_txn(1, 0, 8'h42, 16'hA55A, 0, TO - 20);
    run_txn(2, 0, 8'h90, 16'h0F0F, 1, 0);      // timeout
    run_txn(2, 0, 8'h21, 16'h7777, 0, 3);      // R8: flag survives link reset
    do_reset();
    for (int k = 0; k < 14; k++)
      run_txn($urandom % 6, ($urandom % 8) == 0, 8'($urandom), 16'($urandom), 0, $urandom % (TO - 20));
    do_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule